// File: doc/BRIEF.md
# Matrix Priority Arbiter

This block picks one winner among R requesters every cycle. The relative rank of every pair of requesters is held as a precedence matrix. Entry (i,j) is 1 when requester i currently outranks requester j. Only the bits above the diagonal are stored, one flip-flop per unordered pair. Each bit below the diagonal is the inverse of its mirror bit above it.

A requester wins when it is requesting and it outranks every other active requester. The grant is combinational from the request vector and the stored matrix. When the consumer accepts a grant, the winner drops below every other requester and the order among the rest is kept. Repeated accepts therefore serve requesters in least-recently-served order.

Top module: `mpa_arbiter`

## Requirements
- R1: While reset is high, and after it is released, the stored bit for every pair i<j is 1, which ranks requesters by index. Index 0 has the highest rank. With all requests active in that state, the grant is `00001` (only bit 0 set).
- R2: A grant bit is never set for a requester whose request bit is low. With no request active, the grant vector is all zero.
- R3: The grant vector has at most one bit set, and exactly one bit set whenever any request bit is high.
- R4: Grant bit n is set exactly when request n is high and, for every other active requester i, the matrix ranks n above i. Equivalently, the winner is the active requester that comes first in the current priority order.
- R5: On a rising clock edge where `accept_i` is high and a grant is present, the granted requester moves to the lowest rank against all others. The relative order of the remaining requesters does not change.
- R6: On a rising clock edge where `accept_i` is low, or where no grant is present, the priority order does not change. The same request vector then yields the same grant on the next cycle.
- R7: Under full load (all requests high) with `accept_i` high every cycle, any R consecutive grants go to R different requesters.
- R8: The grant responds to a change in `req_i` within the same cycle, with no register between request and grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the matrix updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the index order |
| req_i | input | R | One request bit per requester |
| accept_i | input | 1 | Consumer takes the current grant; enables the rank update |
| grant_o | output | R | One-hot grant, all zero when nothing is requested |

## Verification
A wrong pair bit in the matrix shows up as a wrong winner. This happens only for request patterns that contain both members of that pair and no active requester ranked above both. So the bench sweeps every request pattern at the reset order and again at a scrambled order, with no update in between. A bad update rule shows up on the first grant that follows it: the granted requester comes back too early, or two others swap places. Under full load the same fault breaks the R-grant coverage window within R cycles.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    // Number of unordered requester pairs, one stored rank bit each.
    function automatic int pair_count(input int r);
        return (r * (r - 1)) / 2;
    endfunction

    // Flat slot of the pair (i,j), i<j, in row-major upper-triangle order.
    function automatic int pair_index(input int i, input int j, input int r);
        return i * r - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction

    // Flat slot of full-matrix entry (row, col).
    function automatic int cell_index(input int row, input int col, input int r);
        return row * r + col;
    endfunction

    // Effect of an accepted grant on one stored pair bit.
    typedef enum logic [1:0] {
        PAIR_HOLD    = 2'd0,
        PAIR_LOW_WON = 2'd1,   // lower index won: it now loses the pair
        PAIR_HIGH_WON = 2'd2   // higher index won: lower index now wins the pair
    } pair_upd_e;

endpackage

// File: rtl/mpa_rank_store.sv
module mpa_rank_store
    import mpa_pkg::*;
#(
    parameter int R = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           upd_en,
    input  logic [R-1:0]   winner,
    output logic [R*R-1:0] rank_mat
);

    localparam int NPAIR = pair_count(R);

    logic [NPAIR-1:0] tri_q;
    logic [NPAIR-1:0] tri_d;
    pair_upd_e        pair_op [NPAIR];

    // Classify each pair against the winner.
    always_comb begin
        for (int i = 0; i < R; i++) begin
            for (int j = i + 1; j < R; j++) begin
                if (!upd_en)
                    pair_op[pair_index(i, j, R)] = PAIR_HOLD;
                else if (winner[i])
                    pair_op[pair_index(i, j, R)] = PAIR_LOW_WON;
                else if (winner[j])
                    pair_op[pair_index(i, j, R)] = PAIR_HIGH_WON;
                else
                    pair_op[pair_index(i, j, R)] = PAIR_HOLD;
            end
        end
    end

    // Next state per pair.
    always_comb begin
        for (int p = 0; p < NPAIR; p++) begin
            unique case (pair_op[p])
                PAIR_LOW_WON:  tri_d[p] = 1'b0;
                PAIR_HIGH_WON: tri_d[p] = 1'b1;
                default:       tri_d[p] = tri_q[p];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tri_q <= '1;
        else
            tri_q <= tri_d;
    end

    // Expand to the full matrix: mirror bits inverted, diagonal unused (0).
    genvar gr, gc;
    generate
        for (gr = 0; gr < R; gr++) begin : g_row
            for (gc = 0; gc < R; gc++) begin : g_col
                if (gr < gc) begin : g_upper
                    assign rank_mat[cell_index(gr, gc, R)] = tri_q[pair_index(gr, gc, R)];
                end else if (gr > gc) begin : g_lower
                    assign rank_mat[cell_index(gr, gc, R)] = ~tri_q[pair_index(gc, gr, R)];
                end else begin : g_diag
                    assign rank_mat[cell_index(gr, gc, R)] = 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mpa_grant_logic.sv
module mpa_grant_logic
    import mpa_pkg::*;
#(
    parameter int R = 5
) (
    input  logic [R-1:0]   req,
    input  logic [R*R-1:0] rank_mat,
    output logic [R-1:0]   grant
);

    // beats[n] : n outranks every other active requester
    logic [R-1:0] beats;

    always_comb begin
        for (int n = 0; n < R; n++) begin
            beats[n] = 1'b1;
            for (int i = 0; i < R; i++) begin
                if (i != n)
                    beats[n] = beats[n] & (~req[i] | rank_mat[cell_index(n, i, R)]);
            end
            grant[n] = req[n] & beats[n];
        end
    end

endmodule

// File: rtl/mpa_arbiter.sv
module mpa_arbiter
    import mpa_pkg::*;
#(
    parameter int R = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [R-1:0] req_i,
    input  logic         accept_i,
    output logic [R-1:0] grant_o
);

    localparam int NCELL = R * R;

    logic [NCELL-1:0] rank_mat;
    logic [R-1:0]     grant;
    logic             upd_en;

    assign upd_en  = accept_i & (|grant);
    assign grant_o = grant;

    mpa_rank_store #(.R(R)) u_store (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (upd_en),
        .winner   (grant),
        .rank_mat (rank_mat)
    );

    mpa_grant_logic #(.R(R)) u_grant (
        .req      (req_i),
        .rank_mat (rank_mat),
        .grant    (grant)
    );

endmodule

// File: rtl/mpa_arbiter_chk.sv
module mpa_arbiter_chk #(
    parameter int R = 5
) (
    input logic         clk,
    input logic         rst,
    input logic [R-1:0] req_i,
    input logic         accept_i,
    input logic [R-1:0] grant_o
);

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R2
    grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~req_i) == '0);

    // R3
    grant_present_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i != '0) |-> (grant_o != '0));

    // R6
    hold_order_chk: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> (req_i != $past(req_i)) || (grant_o == $past(grant_o)));

    // R5
    winner_demoted_chk: assert property (@(posedge clk) disable iff (rst)
        (accept_i && grant_o != '0) |=>
            ((req_i & ~$past(grant_o)) == '0) || ((grant_o & $past(grant_o)) == '0));

endmodule

bind mpa_arbiter mpa_arbiter_chk #(.R(R)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .accept_i (accept_i),
    .grant_o  (grant_o)
);

// File: tb/tb_mpa_arbiter.sv
module tb_mpa_arbiter;

    localparam int R = 5;
    localparam int NPAT = 1 << R;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [R-1:0] req = '0;
    logic         accept = 1'b0;
    logic [R-1:0] grant;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Model: priority order, order[0] ranks highest.
    int order [R];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    mpa_arbiter #(.R(R)) dut (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .accept_i (accept),
        .grant_o  (grant)
    );

    function automatic logic [R-1:0] model_grant(input logic [R-1:0] r);
        logic [R-1:0] g;
        g = '0;
        for (int k = 0; k < R; k++) begin
            if (g == '0 && r[order[k]]) g[order[k]] = 1'b1;
        end
        return g;
    endfunction

    task automatic model_demote(input logic [R-1:0] g);
        int w;
        int pos;
        w = 0;
        pos = 0;
        for (int k = 0; k < R; k++) if (g[k]) w = k;
        for (int k = 0; k < R; k++) if (order[k] == w) pos = k;
        for (int k = pos; k < R - 1; k++) order[k] = order[k+1];
        order[R-1] = w;
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [R-1:0] act, input logic [R-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [R-1:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[R-1:0];
    endfunction

    // Drive away from the edge, check combinational grant, advance the model.
    task automatic step(input logic [R-1:0] r, input logic a, input string tag);
        logic [R-1:0] exp;
        @(negedge clk);
        req = r;
        accept = a;
        #1;
        exp = model_grant(r);
        check(grant == exp, tag, grant, exp);
        check($countones(grant) <= 1 && (grant & ~r) == '0, "R2/R3 onehot-subset", grant, exp);
        if (a && exp != '0) model_demote(exp);
    endtask

    initial begin
        logic [R-1:0] seen;
        logic [R-1:0] g_first;
        for (int k = 0; k < R; k++) order[k] = k;

        // R1: reset state, full load during reset
        req = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(grant == 5'b00001, "R1 reset order during reset", grant, 5'b00001);
        rst = 1'b0;

        // R1 after release
        step('1, 1'b0, "R1 index order after reset");

        // R2: nothing requested
        step('0, 1'b1, "R2 idle grant zero");

        // R4/R6: exhaustive sweep at reset order, no updates
        for (int p = 0; p < NPAT; p++) step(p[R-1:0], 1'b0, "R4 sweep at reset order");

        // R6: accept low holds, repeated request yields same grant
        step(5'b10110, 1'b0, "R6 hold first");
        step(5'b10110, 1'b0, "R6 hold repeat");

        // R5: accepted winner drops to the bottom
        step(5'b11111, 1'b1, "R5 accept winner 0");
        step(5'b00011, 1'b0, "R5 former winner loses to 1");
        step(5'b00001, 1'b0, "R5 alone it still wins");
        step(5'b11110, 1'b1, "R5 accept winner 1");
        step(5'b11100, 1'b0, "R5 others keep order");

        // R4/R5/R6: mixed random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            logic [R-1:0] r;
            r = next_rand();
            step(r, lfsr[9], "R4 random traffic");
        end

        // R4: exhaustive sweep again at a scrambled order
        for (int p = 0; p < NPAT; p++) step(p[R-1:0], 1'b0, "R4 sweep at scrambled order");

        // R8: grant follows request within the cycle
        @(negedge clk);
        req = '0;
        accept = 1'b0;
        #1;
        g_first = grant;
        req = '1;
        #1;
        check(g_first == '0 && grant == model_grant('1), "R8 same-cycle response",
              grant, model_grant('1));

        // R7: full load, every R consecutive grants cover all requesters
        for (int w = 0; w < 4; w++) begin
            seen = '0;
            for (int c = 0; c < R; c++) begin
                step('1, 1'b1, "R7 full-load grant");
                seen = seen | grant;
            end
            check(seen == '1, "R7 no starvation window", seen, '1);
        end

        @(negedge clk);
        req = '0;
        accept = 1'b0;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule